// File: doc/BRIEF.md
# Triggered Single-Shot Sample Capture Controller

This block runs one acquisition for a small sampling oscilloscope. The host first pulses an arm request, which clears the address counter and the capture state. Sampling then stays blocked until the trigger input shows an edge of the chosen polarity. The trigger input is combined with a polarity bit through an XOR, so a single rising-edge detector serves both edge directions. After the trigger, every sample-rate tick writes the converter byte into a 256-entry sample memory at the counter address, and then advances the counter. There is no history from before the trigger.

When the counter wraps from its highest address back to zero, the block raises its done flag and stops writing. The same counter then serves a host-driven readout. The byte stored at the current address is always shown on the read-data output, and each step strobe moves the address forward by one.

Top module: `capture_ctrl`

## Requirements
- R1: After reset, addr is 0, wr_en is 0 and done is 0.
- R2: No write happens and addr does not move while the block is not triggered, whatever sample_tick does. This holds before the first arm, and after an arm but before a trigger edge.
- R3: The trigger fires on a 0-to-1 change of trig_in ^ trig_invert. With trig_invert=0 this is a rising edge of trig_in, and with trig_invert=1 a falling edge. An edge of the other direction does not fire. The edge passes through a two-stage synchronizer, so a sample_tick counts from the third rising clock edge after trig_in changes.
- R4: While the block is triggered and not done, a cycle with sample_tick high drives wr_en high, writes adc_data at addr, and adds one to addr at the clock edge. A cycle without the tick writes nothing and keeps addr.
- R5: The strobe at address 255 sets done and returns addr to 0 at the same edge. A full capture gives exactly 256 writes, to addresses 0 through 255 in order. Once done is set, wr_en stays low and done stays high until the next arm.
- R6: Trigger edges that arrive before an arm, or while done is high, are ignored.
- R7: rd_data always shows the stored byte at addr. While done is high, a cycle with step high adds one to addr, and addr wraps to 0 after 256 steps.
- R8: step has no effect while done is low. This includes the cycle of the final capture strobe.
- R9: arm takes priority over everything else. At the next edge it clears done, the triggered state and addr to 0, so the next write needs a new trigger edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_tick | input | 1 | One-cycle sample-rate strobe |
| trig_in | input | 1 | Asynchronous trigger level |
| trig_invert | input | 1 | 1 selects falling-edge triggering |
| arm | input | 1 | Start a new acquisition |
| step | input | 1 | Readout address advance strobe |
| adc_data | input | DW | Converter byte to store |
| addr | output | AW | Current sample-memory address |
| wr_en | output | 1 | Sample-memory write strobe |
| done | output | 1 | Acquisition finished, buffer readable |
| rd_data | output | DW | Stored byte at addr |

## Verification
Two functions can fall in the same cycle: the capture strobe that wraps the counter, and a host step strobe. The step has to lose, because done is not yet set in that cycle. The bench raises step in the cycle of the 256th sample tick. It then checks that addr lands on exactly 0 with done high, and that the later readout still starts from byte 0. A second clash, arm raised in the middle of a capture, is judged by addr returning to 0 and ticks no longer writing.

// File: rtl/capture_ctrl.sv
module capture_ctrl #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample_tick,
  input  logic          trig_in,
  input  logic          trig_invert,
  input  logic          arm,
  input  logic          step,
  input  logic [DW-1:0] adc_data,
  output logic [AW-1:0] addr,
  output logic          wr_en,
  output logic          done,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [2:0]    trig_pipe;
  logic          armed, fired, done_q;
  logic [AW-1:0] cnt;
  logic [DW-1:0] mem [DEPTH];

  wire trig_lvl  = trig_in ^ trig_invert;
  wire trig_rise = trig_pipe[1] & ~trig_pipe[2];
  wire cap       = sample_tick & fired & ~done_q;
  wire at_top    = &cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_pipe <= '0;
    else        trig_pipe <= {trig_pipe[1:0], trig_lvl};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed  <= 1'b0;
      fired  <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else if (arm) begin
      armed  <= 1'b1;
      fired  <= 1'b0;
      done_q <= 1'b0;
      cnt    <= '0;
    end else begin
      if (armed && !fired && !done_q && trig_rise)
        fired <= 1'b1;
      if (cap) begin
        cnt <= cnt + AW'(1);
        if (at_top) done_q <= 1'b1;
      end else if (done_q && step) begin
        cnt <= cnt + AW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (cap) mem[cnt] <= adc_data;
  end

  assign addr    = cnt;
  assign wr_en   = cap;
  assign done    = done_q;
  assign rd_data = mem[cnt];

  assert_reset_idle_R1: assert property (@(posedge clk)
    !rst_n |=> (addr == '0 && !done && !wr_en));

  assert_no_write_unarmed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> !wr_en);

  assert_addr_advance_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !arm) |=> addr == $past(addr) + AW'(1));

  assert_wrap_sets_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !arm && addr == '1) |=> (done && addr == '0));

  assert_no_write_when_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !wr_en);

  assert_done_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);

  assert_readout_step_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && step && !arm) |=> addr == $past(addr) + AW'(1));

  assert_step_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!done && !wr_en && !arm) |=> $stable(addr));

  assert_arm_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!done && addr == '0 && !wr_en));
endmodule

// File: tb/capture_ctrl_bench.sv
module capture_ctrl_bench;
  localparam int DW = 8;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sample_tick = 1'b0, trig_in = 1'b0, trig_invert = 1'b0;
  logic arm = 1'b0, step = 1'b0;
  logic [DW-1:0] adc_data = '0;
  logic [AW-1:0] addr;
  logic wr_en, done;
  logic [DW-1:0] rd_data;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  capture_ctrl #(.DW(DW), .AW(AW)) u_capture_ctrl (
    .clk(clk), .rst_n(rst_n), .sample_tick(sample_tick), .trig_in(trig_in),
    .trig_invert(trig_invert), .arm(arm), .step(step), .adc_data(adc_data),
    .addr(addr), .wr_en(wr_en), .done(done), .rd_data(rd_data)
  );

  function automatic logic [7:0] pat(input int seed, input int k);
    return 8'((k * (2 * seed + 1) + 17 * seed + 3) & 255);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc;
    @(negedge clk);
  endtask

  task automatic pulse_arm;
    cyc(); arm = 1'b1;
    cyc(); arm = 1'b0;
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) cyc();
    #1;
    check(addr == 0, "R1 addr", addr, 0);
    check(wr_en == 0, "R1 wr_en", wr_en, 0);
    check(done == 0, "R1 done", done, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_unarmed;
    int bad = 0;
    trig_invert = 1'b0; trig_in = 1'b0;
    repeat (4) cyc();
    trig_in = 1'b1;
    repeat (5) cyc();
    for (int i = 0; i < 6; i++) begin
      cyc(); sample_tick = 1'b1; #1;
      if (wr_en) bad++;
    end
    cyc(); sample_tick = 1'b0; #1;
    check(bad == 0, "R6 edge before arm ignored", bad, 0);
    check(addr == 0, "R2 addr idle", addr, 0);
    trig_in = 1'b0;
    repeat (4) cyc();
    pulse_arm();
    bad = 0;
    for (int i = 0; i < 8; i++) begin
      cyc(); sample_tick = (i % 2 == 0); #1;
      if (wr_en) bad++;
    end
    cyc(); sample_tick = 1'b0; #1;
    check(bad == 0, "R2 armed but untriggered", bad, 0);
    check(addr == 0, "R2 addr untriggered", addr, 0);
  endtask

  task automatic t_wrong_edge;
    int bad = 0;
    trig_invert = 1'b0; trig_in = 1'b1;
    repeat (4) cyc();
    pulse_arm();
    trig_in = 1'b0;
    repeat (4) cyc();
    for (int i = 0; i < 6; i++) begin
      cyc(); sample_tick = 1'b1; step = 1'b1; #1;
      if (wr_en) bad++;
    end
    cyc(); sample_tick = 1'b0; step = 1'b0; #1;
    check(bad == 0, "R3 falling edge ignored with trig_invert=0", bad, 0);
    check(addr == 0, "R8 step ignored before done", addr, 0);
    check(done == 0, "R3 no done", done, 0);
  endtask

  task automatic t_capture(input bit inv, input int seed);
    int writes = 0, bad_addr = 0, bad_gap = 0, bad_data = 0;
    logic [7:0] idle;
    idle = inv ? 8'd1 : 8'd0;
    trig_invert = inv; trig_in = idle[0];
    repeat (4) cyc();
    pulse_arm();
    trig_in = ~idle[0];
    cyc(); cyc();
    sample_tick = 1'b1; #1;
    check(wr_en == 0, "R3 tick before sync latency", wr_en, 0);
    cyc(); sample_tick = 1'b0;
    for (int k = 0; k < 256; k++) begin
      if (k % 5 == 2) begin
        cyc(); sample_tick = 1'b0; #1;
        if (wr_en || addr != 8'(k)) bad_gap++;
      end
      cyc();
      sample_tick = 1'b1; adc_data = pat(seed, k); step = (k == 255);
      #1;
      if (wr_en) writes++;
      if (addr != 8'(k)) bad_addr++;
    end
    cyc(); sample_tick = 1'b0; step = 1'b0; #1;
    check(writes == 256, inv ? "R3 falling trigger writes" : "R3 rising trigger writes", writes, 256);
    check(bad_addr == 0, "R4 address sequence", bad_addr, 0);
    check(bad_gap == 0, "R4 no write without tick", bad_gap, 0);
    check(done == 1, "R5 done after wrap", done, 1);
    check(addr == 0, "R8 step at final strobe ignored, addr wraps to 0", addr, 0);
    writes = 0;
    for (int i = 0; i < 10; i++) begin
      cyc(); sample_tick = 1'b1; trig_in = (i % 2 == 0) ? idle[0] : ~idle[0]; #1;
      if (wr_en) writes++;
    end
    cyc(); sample_tick = 1'b0; trig_in = ~idle[0];
    repeat (4) cyc(); #1;
    check(writes == 0, "R5 no write after done", writes, 0);
    check(done == 1 && addr == 0, "R6 edges after done ignored", addr, 0);
    for (int k = 0; k < 256; k++) begin
      cyc(); step = 1'b0; #1;
      if (rd_data != pat(seed, k) || addr != 8'(k)) bad_data++;
      cyc(); step = 1'b1;
    end
    cyc(); step = 1'b0; #1;
    check(bad_data == 0, "R7 readout bytes", bad_data, 0);
    check(addr == 0, "R7 readout wrap", addr, 0);
    check(rd_data == pat(seed, 0), "R7 byte 0 after wrap", rd_data, pat(seed, 0));
  endtask

  task automatic t_arm_midway;
    int bad = 0;
    trig_invert = 1'b0; trig_in = 1'b0;
    repeat (4) cyc();
    pulse_arm();
    trig_in = 1'b1;
    repeat (3) cyc();
    for (int k = 0; k < 10; k++) begin
      cyc(); sample_tick = 1'b1; adc_data = 8'(k);
    end
    cyc(); sample_tick = 1'b0; #1;
    check(addr == 10, "R4 partial capture addr", addr, 10);
    arm = 1'b1; sample_tick = 1'b1; step = 1'b1;
    cyc(); arm = 1'b0; step = 1'b0; #1;
    check(addr == 0, "R9 arm clears addr", addr, 0);
    check(done == 0, "R9 arm clears done", done, 0);
    for (int i = 0; i < 5; i++) begin
      cyc(); sample_tick = 1'b1; #1;
      if (wr_en) bad++;
    end
    cyc(); sample_tick = 1'b0; #1;
    check(bad == 0, "R9 trigger cleared by arm", bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_unarmed();
    t_wrong_edge();
    t_capture(1'b0, 1);
    t_capture(1'b1, 6);
    t_arm_midway();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule